// File: doc/BRIEF.md
# Bit-Serial FIR Band Classifier

This block accepts unsigned 10-bit samples one bit at a time on a separate bit clock, framed by a handshake line. The bit clock shifts the sample in while the handshake is high. When the handshake drops, the block runs one filter update on the system clock. The update pushes the sample into a tap history. A single shared multiplier-accumulator then walks a constant coefficient table, one product per system clock cycle.

At the end of the walk the accumulator is divided by 2^15 by taking a fixed 8-bit slice. The result is sorted into one of three classes: a low window, a high window, or neither. Two registered indicator outputs show the class. They change only when an accumulation finishes.

Top module: `fir_band_sorter`

## Requirements
- R1: On each rising edge of `bitClk` with `hsLine` high, the sample register shifts right by one and `serBit` enters bit 9, so a sample is sent least significant bit first. Edges of `bitClk` while `hsLine` is low leave the sample unchanged.
- R2: A falling handshake starts exactly one filter update. No further update runs until `hsLine` has been seen high again, however long it stays low.
- R3: An update first moves every stored sample one place older, dropping the oldest. It then stores the new sample as the newest entry.
- R4: The coefficient paired with the tap at age k (0 = newest) of an N-tap filter is COEF_UNIT*(min(k, N-1-k)+1), a signed 17-bit value. The table is symmetric, and the default is N=5, COEF_UNIT=3641.
- R5: The 32-bit signed accumulator is cleared at the start of each update and gains one coefficient-times-sample product per system clock for N cycles. The filter output is accumulator bits [22:15], read as a signed 8-bit number.
- R6: If the filter output is between 40 and 60 inclusive, both `indHigh` and `indOther` are 0.
- R7: If the filter output is between 90 and 110 inclusive, `indHigh` is 1 and `indOther` is 0. The two indicators are never both 1.
- R8: For any other filter output, `indHigh` is 0 and `indOther` is 1.
- R9: The indicators change only when an accumulation completes. They hold their previous values while an update is in progress, and the new values appear within N+8 system clocks of the handshake falling.
- R10: A synchronous reset on `clk` clears the tap history, the accumulator and the update-blocking flag. It sets `indHigh` to 0 and `indOther` to 1, and they stay there until the first update completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the filter and the indicators |
| rst | input | 1 | Synchronous reset, active high, on `clk` |
| bitClk | input | 1 | Bit clock for serial sample entry |
| serBit | input | 1 | Serial sample data, least significant bit first |
| hsLine | input | 1 | Handshake: high while loading, falling edge starts an update |
| indHigh | output | 1 | High-window indicator |
| indOther | output | 1 | Out-of-both-windows indicator |

## Verification
The bench builds the block with five taps and a coefficient unit of 3641. With these values the weights sum to just over 2^15, so a constant input filling the taps gives an output equal to the low byte of the sample. That makes every window edge, and the 8-bit wrap into those windows, reachable on purpose. The short tap history makes transients between unlike samples frequent. A bench-side reference sum of weighted taps then catches any error in tap order, weight or accumulator clearing. Garbage bit-clock pulses while the handshake is low, long handshake-low holds and a reset between updates cover the serial gating, the single-update rule and the cleared state.

// File: rtl/fir_band_pkg.sv
package fir_band_pkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic shiftTaps;
    logic clearAcc;
    logic macEn;
    logic loadInd;
  } firStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAC,
    ST_LOAD
  } firState_t;

  // Symmetric triangular weight for tap age k
  function automatic int tapWeight(input int k, input int nTaps, input int unit);
    int m;
    m = (k < nTaps - 1 - k) ? k : nTaps - 1 - k;
    return unit * (m + 1);
  endfunction

endpackage

// File: rtl/fir_band_deser.sv
module fir_band_deser #(
  parameter int SAMPLE_W = 10
) (
  input  logic                bitClk,
  input  logic                serBit,
  input  logic                hsLine,
  output logic [SAMPLE_W-1:0] sampleWord
);

  logic [SAMPLE_W-1:0] shiftReg;

  always_ff @(posedge bitClk) begin
    if (hsLine) shiftReg <= {serBit, shiftReg[SAMPLE_W-1:1]};
  end

  assign sampleWord = shiftReg;

  AST_GATED_SHIFT: assert property (@(posedge bitClk)
    !hsLine |=> $stable(shiftReg)); // R1

endmodule

// File: rtl/fir_band_ctrl.sv
module fir_band_ctrl
  import fir_band_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsLine,
  output firStrobes_t      strobes,
  output logic [IDX_W-1:0] tapIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NTAPS - 1);

  logic      hsMeta;
  logic      hsSync;
  logic      sentFlag;
  logic      startNow;
  firState_t state;

  // Bring the handshake into the system clock domain
  always_ff @(posedge clk) begin
    if (rst) begin
      hsMeta <= 1'b1;
      hsSync <= 1'b1;
    end else begin
      hsMeta <= hsLine;
      hsSync <= hsMeta;
    end
  end

  assign startNow = (state == ST_IDLE) && !hsSync && !sentFlag;

  always_ff @(posedge clk) begin
    if (rst)           sentFlag <= 1'b0;
    else if (hsSync)   sentFlag <= 1'b0;
    else if (startNow) sentFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tapIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state  <= ST_MAC;
            tapIdx <= '0;
          end
        end
        ST_MAC: begin
          if (tapIdx == LAST_IDX) state <= ST_LOAD;
          else                    tapIdx <= tapIdx + IDX_W'(1);
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftTaps = startNow;
    strobes.clearAcc  = startNow;
    strobes.macEn     = (state == ST_MAC);
    strobes.loadInd   = (state == ST_LOAD);
  end

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftTaps |=> !strobes.shiftTaps); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (sentFlag && !hsSync) |-> !strobes.shiftTaps); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MAC) |-> (tapIdx <= LAST_IDX)); // R5
  AST_MAC_TO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (strobes.macEn && tapIdx == LAST_IDX) |=> strobes.loadInd); // R9

endmodule

// File: rtl/fir_band_dp.sv
module fir_band_dp
  import fir_band_pkg::*;
#(
  parameter int NTAPS     = 5,
  parameter int IDX_W     = 3,
  parameter int SAMPLE_W  = 10,
  parameter int COEF_W    = 17,
  parameter int ACC_W     = 32,
  parameter int COEF_UNIT = 3641,
  parameter int OUT_SHIFT = 15,
  parameter int OUT_W     = 8,
  parameter int LOW_MIN   = 40,
  parameter int LOW_MAX   = 60,
  parameter int HIGH_MIN  = 90,
  parameter int HIGH_MAX  = 110
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleWord,
  input  firStrobes_t         strobes,
  input  logic [IDX_W-1:0]    tapIdx,
  output logic                indHigh,
  output logic                indOther
);

  localparam int PROD_W = COEF_W + SAMPLE_W + 1;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic        [SAMPLE_W-1:0] taps    [NTAPS];
  logic signed [COEF_W-1:0]   coefRom [NTAPS];
  logic signed [COEF_W-1:0]   coefSel;
  logic        [SAMPLE_W-1:0] tapSel;
  logic signed [PROD_W-1:0]   product;
  logic signed [ACC_W-1:0]    acc;
  logic signed [OUT_W-1:0]    scaledOut;
  logic                       inLow;
  logic                       inHigh;

  // Constant coefficient table, one entry per tap age
  for (genvar g = 0; g < NTAPS; g++) begin : gCoef
    assign coefRom[g] = COEF_W'(tapWeight(g, NTAPS, COEF_UNIT));
  end

  // Tap history: index 0 holds the newest sample
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
    end else if (strobes.shiftTaps) begin
      for (int k = NTAPS - 1; k > 0; k--) taps[k] <= taps[k-1];
      taps[0] <= sampleWord;
    end
  end

  assign coefSel = coefRom[tapIdx];
  assign tapSel  = taps[tapIdx];
  assign product = coefSel * $signed({1'b0, tapSel});

  always_ff @(posedge clk) begin
    if (rst)                   acc <= '0;
    else if (strobes.clearAcc) acc <= '0;
    else if (strobes.macEn)    acc <= acc + {{EXT_W{product[PROD_W-1]}}, product};
  end

  assign scaledOut = acc[OUT_SHIFT +: OUT_W];
  assign inLow     = (scaledOut >= LOW_MIN)  && (scaledOut <= LOW_MAX);
  assign inHigh    = (scaledOut >= HIGH_MIN) && (scaledOut <= HIGH_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      indHigh  <= 1'b0;
      indOther <= 1'b1;
    end else if (strobes.loadInd) begin
      indHigh  <= inHigh;
      indOther <= !inLow && !inHigh;
    end
  end

  AST_IND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadInd |=> $stable({indHigh, indOther})); // R9
  AST_IND_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(indHigh && indOther)); // R7
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAcc |=> (acc == '0)); // R5
  AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftTaps |=> (taps[0] == $past(sampleWord))); // R3
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!indHigh && indOther && acc == '0)); // R10

endmodule

// File: rtl/fir_band_sorter.sv
module fir_band_sorter
  import fir_band_pkg::*;
#(
  parameter int NTAPS     = 5,
  parameter int SAMPLE_W  = 10,
  parameter int COEF_W    = 17,
  parameter int ACC_W     = 32,
  parameter int COEF_UNIT = 3641,
  parameter int OUT_SHIFT = 15,
  parameter int OUT_W     = 8,
  parameter int LOW_MIN   = 40,
  parameter int LOW_MAX   = 60,
  parameter int HIGH_MIN  = 90,
  parameter int HIGH_MAX  = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic bitClk,
  input  logic serBit,
  input  logic hsLine,
  output logic indHigh,
  output logic indOther
);

  localparam int IDX_W = (NTAPS > 1) ? $clog2(NTAPS) : 1;

  logic [SAMPLE_W-1:0] sampleWord;
  firStrobes_t         strobes;
  logic [IDX_W-1:0]    tapIdx;

  fir_band_deser #(.SAMPLE_W(SAMPLE_W)) deser_i (
    .bitClk    (bitClk),
    .serBit    (serBit),
    .hsLine    (hsLine),
    .sampleWord(sampleWord)
  );

  fir_band_ctrl #(.NTAPS(NTAPS), .IDX_W(IDX_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .hsLine (hsLine),
    .strobes(strobes),
    .tapIdx (tapIdx)
  );

  fir_band_dp #(
    .NTAPS    (NTAPS),
    .IDX_W    (IDX_W),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W),
    .COEF_UNIT(COEF_UNIT),
    .OUT_SHIFT(OUT_SHIFT),
    .OUT_W    (OUT_W),
    .LOW_MIN  (LOW_MIN),
    .LOW_MAX  (LOW_MAX),
    .HIGH_MIN (HIGH_MIN),
    .HIGH_MAX (HIGH_MAX)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .sampleWord(sampleWord),
    .strobes   (strobes),
    .tapIdx    (tapIdx),
    .indHigh   (indHigh),
    .indOther  (indOther)
  );

endmodule

// File: tb/fir_band_sorter_tb_top.sv
module fir_band_sorter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NTAPS      = 5;
  localparam int UNIT       = 3641;

  logic clk    = 1'b0;
  logic rst    = 1'b1;
  logic bitClk = 1'b0;
  logic serBit = 1'b0;
  logic hsLine = 1'b1;
  logic indHigh;
  logic indOther;

  int  checks   = 0;
  int  errors   = 0;
  bit  finished = 1'b0;
  int  model [NTAPS];
  int unsigned seed = 32'd12345;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_band_sorter #(.NTAPS(NTAPS), .COEF_UNIT(UNIT)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .bitClk  (bitClk),
    .serBit  (serBit),
    .hsLine  (hsLine),
    .indHigh (indHigh),
    .indOther(indOther)
  );

  // R4: weight for tap age k
  function automatic int weightOf(input int k);
    int m;
    m = (k < NTAPS - 1 - k) ? k : NTAPS - 1 - k;
    return UNIT * (m + 1);
  endfunction

  // R5: 32-bit accumulator, output is bits [22:15] signed
  function automatic int predictY();
    longint    s;
    logic [31:0] accBits;
    logic [7:0]  slice;
    s = 0;
    for (int k = 0; k < NTAPS; k++) s += longint'(weightOf(k)) * longint'(model[k]);
    accBits = s[31:0];
    slice   = accBits[22:15];
    return int'($signed(slice));
  endfunction

  task automatic checkPair(input string tag, input logic gotH, input logic gotO,
                           input logic expH, input logic expO);
    checks++;
    if (gotH !== expH || gotO !== expO) begin
      errors++;
      $display("FAIL %s indHigh/indOther actual %b%b expected %b%b", tag, gotH, gotO, expH, expO);
    end
  endtask

  task automatic checkModel(input string extra);
    int y;
    logic eH, eO;
    string tag;
    y = predictY();
    if (y >= 40 && y <= 60)       begin eH = 1'b0; eO = 1'b0; tag = "R6"; end
    else if (y >= 90 && y <= 110) begin eH = 1'b1; eO = 1'b0; tag = "R7"; end
    else                          begin eH = 1'b0; eO = 1'b1; tag = "R8"; end
    checkPair($sformatf("%s/%s y=%0d", tag, extra, y), indHigh, indOther, eH, eO);
  endtask

  // R1: LSB first while handshake high
  task automatic shiftIn(input int v);
    hsLine = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 10; i++) begin
      serBit = v[i];
      #1 bitClk = 1'b1;
      #2 bitClk = 1'b0;
      #1;
    end
  endtask

  task automatic runUpdate(input int v, input bit garbage, input int extraHold);
    logic pH, pO, nH, nO;
    shiftIn(v);
    hsLine = 1'b0;
    if (garbage) begin
      // R1: these edges arrive with the handshake low and must be ignored
      repeat (3) begin
        serBit = ~serBit;
        #1 bitClk = 1'b1;
        #1 bitClk = 1'b0;
      end
    end
    pH = indHigh;
    pO = indOther;
    for (int k = NTAPS - 1; k > 0; k--) model[k] = model[k-1];  // R3
    model[0] = v & 1023;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkPair("R9 hold during accumulation", indHigh, indOther, pH, pO);
    repeat (NTAPS + 3) @(posedge clk);
    @(negedge clk);
    checkModel(garbage ? "R1" : "R9");
    if (extraHold > 0) begin
      nH = indHigh;
      nO = indOther;
      repeat (extraHold) @(posedge clk);
      @(negedge clk);
      checkPair("R2 no second update while low", indHigh, indOther, nH, nO);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dcList [13] = '{40, 60, 39, 61, 90, 110, 89, 111, 0, 75, 200, 1023, 296};
    for (int k = 0; k < NTAPS; k++) model[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkPair("R10 reset state", indHigh, indOther, 1'b0, 1'b1);

    // Constant runs: output settles to the sample's low byte, hitting window edges and wrap
    foreach (dcList[j]) begin
      for (int r = 0; r < NTAPS; r++) runUpdate(dcList[j], 1'b0, 0);
    end

    // R3 R4 R5: mixed samples expose tap order, weights and per-update clearing
    for (int n = 0; n < 120; n++) begin
      int v;
      seed = seed * 32'd1103515245 + 32'd12345;
      v = int'((seed >> 16) & 32'd1023);
      runUpdate(v, (n % 3) == 0, ((n % 5) == 0) ? 3 * NTAPS : 0);
    end

    // R10: reset between updates clears the history
    hsLine = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NTAPS; k++) model[k] = 0;
    @(negedge clk);
    checkPair("R10 state after second reset", indHigh, indOther, 1'b0, 1'b1);
    runUpdate(500, 1'b0, 0);  // R10: only the newest tap contributes
    runUpdate(900, 1'b1, 2 * NTAPS);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule